// File: doc/BRIEF.md
# Parallel Combining Tree: Broadcast, Reduction, Prefix Scan and Barrier

This block joins a controller to a fixed set of processing-element ports through a pipelined binary tree. One tree carries four collective operations. A broadcast copies a controller value to every participating port. A reduction folds one value per port into a single result, using bitwise OR, unsigned maximum or wrapping sum. An inclusive prefix scan returns to each port the fold of all ports up to and including its own index. A barrier releases every participating port in the same cycle once all of them have arrived.

The controller issues a command that carries an operation code, an operator code, a participation mask and a broadcast value. Ports then raise their valid lines, with data where the operation needs it. Ports outside the mask contribute zero, which is the identity of all three operators, and their valid lines are ignored. The block accepts one command at a time. While a command is in flight the busy output is high, and any command offered during that time is dropped. Completion is shown by a one-cycle `done` pulse. On the same cycle, per-port valid pulses appear for broadcast, scan and barrier.

Top module: `comb_tree_net`

## Requirements
- R1: A command with operation code 0 (broadcast) is accepted whenever busy is low. On the next clock edge, `done` pulses, `pe_out_valid` equals the mask, every masked port's slice of `pe_out_data` equals `cmd_value`, and `result` equals `cmd_value`. Busy stays low.
- R2: Operation code 1 (reduce) with operator code 0 sets `result` to the bitwise OR of the participating ports' data. Operator code 3 behaves exactly like code 0.
- R3: Reduce with operator code 1 sets `result` to the unsigned maximum of the participating ports' data.
- R4: Reduce with operator code 2 sets `result` to the sum of the participating ports' data, modulo 2^WIDTH.
- R5: Operation code 2 (scan) sets slice i of `pe_out_data` (bits i*WIDTH upward) to the fold of ports 0..i under the chosen operator. Every masked port's valid rises in the same cycle, and `result` carries the fold of all ports.
- R6: A port outside the mask contributes 0, and its `pe_valid` and `pe_data` have no effect. An empty mask yields a result of 0.
- R7: For reduce and scan, `done` rises exactly log2(NPORT) clock edges after the edge on which the last participating `pe_valid` is sampled, and not earlier.
- R8: Operation code 3 (barrier) gives no `done` and no `pe_out_valid` until every masked port has raised `pe_valid`. On the edge that samples the last arrival, `done` pulses, `pe_out_valid` equals the mask for exactly one cycle, and `result` is 0.
- R9: Busy is high from the edge after a non-broadcast command is accepted until its completion edge. A command offered while busy is ignored.
- R10: After reset, busy, `done`, `pe_out_valid` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 0 broadcast, 1 reduce, 2 scan, 3 barrier |
| cmd_fn | input | 2 | 0 OR, 1 unsigned max, 2 wrapping sum, 3 OR |
| cmd_mask | input | NPORT | Participating ports |
| cmd_value | input | WIDTH | Broadcast value |
| busy | output | 1 | A command is in flight |
| pe_valid | input | NPORT | Per-port arrival / data valid |
| pe_data | input | NPORT*WIDTH | Per-port data, port i at bits i*WIDTH upward |
| pe_out_valid | output | NPORT | Per-port completion pulse |
| pe_out_data | output | NPORT*WIDTH | Per-port broadcast value or prefix |
| done | output | 1 | One-cycle completion pulse |
| result | output | WIDTH | Reduction total, scan total or broadcast value |

## Verification
The bench builds the tree with four ports of eight bits, so it has two levels. With that configuration, every one of the sixteen participation masks can be swept under all four operator codes, for both reduce and scan and for two data patterns. One of those patterns is chosen so that the sum wraps. Barrier and broadcast are swept over all masks too. Ports arrive either together or one per cycle in descending order. Ports outside the mask keep offering 0xFF, so that any leak would show up in the maximum and the OR. Half the runs also offer a stray command while busy, which exercises the drop rule.

// File: rtl/comb_tree_pkg.sv
package comb_tree_pkg;
  typedef enum logic [1:0] {
    OP_BCAST   = 2'd0,
    OP_REDUCE  = 2'd1,
    OP_SCAN    = 2'd2,
    OP_BARRIER = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    FN_OR  = 2'd0,
    FN_MAX = 2'd1,
    FN_SUM = 2'd2,
    FN_ALT = 2'd3
  } fn_e;
endpackage

// File: rtl/comb_tree_level.sv
// One level of the prefix tree: lane i folds in lane i-DIST.
module comb_tree_level #(
  parameter int NP   = 16,
  parameter int W    = 32,
  parameter int DIST = 1
) (
  input  logic [1:0]      fn,
  input  logic [NP*W-1:0] din,
  output logic [NP*W-1:0] dout
);
  function automatic logic [W-1:0] fold(input logic [1:0] f,
                                        input logic [W-1:0] a,
                                        input logic [W-1:0] b);
    case (f)
      2'd1:    fold = (a > b) ? a : b;
      2'd2:    fold = a + b;
      default: fold = a | b;
    endcase
  endfunction

  for (genvar i = 0; i < NP; i++) begin : g_lane
    if (i >= DIST) begin : g_fold
      assign dout[i*W +: W] = fold(fn, din[(i-DIST)*W +: W], din[i*W +: W]);
    end else begin : g_pass
      assign dout[i*W +: W] = din[i*W +: W];
    end
  end
endmodule

// File: rtl/comb_tree_gather.sv
// Collects per-port arrivals and data for the command in flight.
module comb_tree_gather #(
  parameter int NP = 16,
  parameter int W  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            en,
  input  logic [NP-1:0]   mask,
  input  logic [NP-1:0]   valid,
  input  logic [NP*W-1:0] data,
  output logic            all_in,
  output logic [NP*W-1:0] cur
);
  logic [NP-1:0] arrived;
  logic [W-1:0]  held [NP];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      arrived <= '0;
    end else if (en) begin
      arrived <= arrived | (valid & mask);
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_port
    always_ff @(posedge clk) begin
      if (en && valid[i] && mask[i]) begin
        held[i] <= data[i*W +: W];
      end
    end

    always_comb begin
      if (!mask[i]) begin
        cur[i*W +: W] = '0;
      end else if (valid[i]) begin
        cur[i*W +: W] = data[i*W +: W];
      end else begin
        cur[i*W +: W] = held[i];
      end
    end
  end

  assign all_in = &(arrived | (valid & mask) | ~mask);
endmodule

// File: rtl/comb_tree_ctrl.sv
// Command sequencing: idle, gathering arrivals, running the tree.
module comb_tree_ctrl
  import comb_tree_pkg::*;
#(
  parameter int NP   = 16,
  parameter int LOG2 = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [1:0]    cmd_fn,
  input  logic [NP-1:0] cmd_mask,
  input  logic          all_in,
  output logic          accept,
  output logic          gathering,
  output logic          load,
  output logic          rel,
  output logic          finish,
  output logic          busy,
  output op_e           op_q,
  output logic [1:0]    fn_q,
  output logic [NP-1:0] mask_q
);
  localparam int CW = (LOG2 > 1) ? $clog2(LOG2) : 1;

  typedef enum logic [1:0] {S_IDLE, S_GATHER, S_RUN} state_e;
  state_e        state;
  logic [CW-1:0] cnt;

  always_comb begin
    accept    = cmd_valid && (state == S_IDLE);
    gathering = (state == S_GATHER);
    load      = gathering && all_in && (op_q != OP_BARRIER);
    rel       = gathering && all_in && (op_q == OP_BARRIER);
    finish    = (state == S_RUN) && (cnt == CW'(LOG2 - 1));
    busy      = (state != S_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      op_q   <= OP_BCAST;
      fn_q   <= '0;
      mask_q <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            op_q   <= op_e'(cmd_op);
            fn_q   <= cmd_fn;
            mask_q <= cmd_mask;
            if (op_e'(cmd_op) != OP_BCAST) state <= S_GATHER;
          end
        end
        S_GATHER: begin
          if (load) begin
            state <= S_RUN;
            cnt   <= '0;
          end else if (rel) begin
            state <= S_IDLE;
          end
        end
        default: begin
          if (finish) state <= S_IDLE;
          else        cnt   <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/comb_tree_net.sv
module comb_tree_net
  import comb_tree_pkg::*;
#(
  parameter int NPORT = 16,
  parameter int WIDTH = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_op,
  input  logic [1:0]             cmd_fn,
  input  logic [NPORT-1:0]       cmd_mask,
  input  logic [WIDTH-1:0]       cmd_value,
  output logic                   busy,
  input  logic [NPORT-1:0]       pe_valid,
  input  logic [NPORT*WIDTH-1:0] pe_data,
  output logic [NPORT-1:0]       pe_out_valid,
  output logic [NPORT*WIDTH-1:0] pe_out_data,
  output logic                   done,
  output logic [WIDTH-1:0]       result
);
  localparam int LOG2 = $clog2(NPORT);
  localparam int VW   = NPORT * WIDTH;

  logic             accept, gathering, load, rel, finish, all_in;
  op_e              op_q;
  logic [1:0]       fn_q;
  logic [NPORT-1:0] mask_q;
  logic [VW-1:0]    cur, bvec;
  logic [VW-1:0]    st  [LOG2];
  logic [VW-1:0]    nxt [LOG2];

  comb_tree_ctrl #(.NP(NPORT), .LOG2(LOG2)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_fn(cmd_fn), .cmd_mask(cmd_mask), .all_in(all_in),
    .accept(accept), .gathering(gathering), .load(load), .rel(rel),
    .finish(finish), .busy(busy), .op_q(op_q), .fn_q(fn_q), .mask_q(mask_q)
  );

  comb_tree_gather #(.NP(NPORT), .W(WIDTH)) u_gather (
    .clk(clk), .rst(rst), .clear(accept), .en(gathering), .mask(mask_q),
    .valid(pe_valid), .data(pe_data), .all_in(all_in), .cur(cur)
  );

  for (genvar k = 0; k < LOG2; k++) begin : g_lvl
    comb_tree_level #(.NP(NPORT), .W(WIDTH), .DIST(1 << k)) u_lvl (
      .fn(fn_q), .din(st[k]), .dout(nxt[k])
    );
  end

  // One register per level; level 0 loads when the last arrival is seen.
  always_ff @(posedge clk) begin
    if (load) st[0] <= cur;
    for (int k = 1; k < LOG2; k++) st[k] <= nxt[k-1];
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      bvec[i*WIDTH +: WIDTH] = cmd_mask[i] ? cmd_value : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done         <= 1'b0;
      pe_out_valid <= '0;
      pe_out_data  <= '0;
      result       <= '0;
    end else begin
      done         <= 1'b0;
      pe_out_valid <= '0;
      if (accept && (op_e'(cmd_op) == OP_BCAST)) begin
        done         <= 1'b1;
        pe_out_valid <= cmd_mask;
        pe_out_data  <= bvec;
        result       <= cmd_value;
      end else if (rel) begin
        done         <= 1'b1;
        pe_out_valid <= mask_q;
        result       <= '0;
      end else if (finish) begin
        done   <= 1'b1;
        result <= nxt[LOG2-1][VW-1 -: WIDTH];
        if (op_q == OP_SCAN) begin
          pe_out_valid <= mask_q;
          pe_out_data  <= nxt[LOG2-1];
        end
      end
    end
  end
endmodule

// File: rtl/comb_tree_chk.sv
module comb_tree_chk #(
  parameter int NP   = 16,
  parameter int LOG2 = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic [NP-1:0] pe_out_valid,
  input logic [NP-1:0] mask_q,
  input logic [1:0]    op_q,
  input logic          load,
  input logic          finish
);
  localparam int CW = $clog2(LOG2 + 2);
  logic [CW-1:0] since_load;

  always_ff @(posedge clk) begin
    if (rst)                   since_load <= '0;
    else if (load)             since_load <= CW'(1);
    else if (finish)           since_load <= '0;
    else if (since_load != '0) since_load <= since_load + 1'b1;
  end

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
  AST_RELEASE_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
    (|pe_out_valid) |-> (pe_out_valid == mask_q)); // R8
  AST_TREE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    finish |-> (since_load == CW'(LOG2))); // R7
  AST_CMD_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(op_q) && $stable(mask_q))); // R9
endmodule

bind comb_tree_net comb_tree_chk #(.NP(NPORT), .LOG2(LOG2)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .pe_out_valid(pe_out_valid),
  .mask_q(mask_q), .op_q(op_q), .load(load), .finish(finish)
);

// File: tb/tb_comb_tree_net.sv
module tb_comb_tree_net;
  localparam int NP   = 4;
  localparam int W    = 8;
  localparam int LOG2 = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = '0;
  logic [1:0]    cmd_fn = '0;
  logic [NP-1:0] cmd_mask = '0;
  logic [W-1:0]  cmd_value = '0;
  logic          busy;
  logic [NP-1:0] pe_valid = '0;
  logic [NP*W-1:0] pe_data = '0;
  logic [NP-1:0] pe_out_valid;
  logic [NP*W-1:0] pe_out_data;
  logic          done;
  logic [W-1:0]  result;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  comb_tree_net #(.NPORT(NP), .WIDTH(W)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_fn(cmd_fn), .cmd_mask(cmd_mask), .cmd_value(cmd_value), .busy(busy),
    .pe_valid(pe_valid), .pe_data(pe_data), .pe_out_valid(pe_out_valid),
    .pe_out_data(pe_out_data), .done(done), .result(result)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  function automatic logic [W-1:0] ref_fold(input int fn, input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    if (fn == 1)      return (a > b) ? a : b;
    else if (fn == 2) return W'(a + b);
    else              return a | b;
  endfunction

  function automatic string tag_for(input int op, input int fn);
    if (op == 3)      return "R8";
    else if (op == 2) return "R5";
    else if (fn == 1) return "R3";
    else if (fn == 2) return "R4";
    else              return "R2";
  endfunction

  task automatic run_bcast(input logic [NP-1:0] m, input logic [W-1:0] v);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_mask = m; cmd_value = v;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R1 done", done, 1);
    chk("R1 busy", busy, 0);
    chk("R1 valid", pe_out_valid, m);
    chk("R1 result", result, v);
    for (int i = 0; i < NP; i++)
      if (m[i]) chk("R1 port data", pe_out_data[i*W +: W], v);
    @(negedge clk);
    chk("R1 pulse", {done, pe_out_valid}, 0);
  endtask

  task automatic run_op(input int op, input int fn, input logic [NP-1:0] m,
                        input int pat, input bit stag, input bit spur);
    logic [W-1:0] d [NP];
    logic [W-1:0] pre [NP];
    logic [W-1:0] acc;
    int rem;
    int n;
    string tg;
    tg = tag_for(op, fn);
    acc = '0;
    rem = 0;
    for (int i = 0; i < NP; i++) begin
      d[i] = (pat == 0) ? W'(i*73 + int'(m)*29 + fn*11 + 5) : W'(8'hC0 | i);
      if (m[i]) begin
        acc = ref_fold(fn, acc, d[i]);
        rem++;
      end
      pre[i] = acc;
      pe_data[i*W +: W] = m[i] ? d[i] : 8'hFF;  // R6: outsiders offer FF
    end

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_fn = 2'(fn); cmd_mask = m; cmd_value = 8'h33;
    @(negedge clk);
    chk("R9 busy after accept", busy, 1);
    cmd_valid = spur; cmd_op = 2'd0; cmd_mask = '1; cmd_value = 8'h5A;

    if (stag && rem > 0) begin
      for (int p = NP - 1; p >= 0; p--) begin
        if (m[p]) begin
          pe_valid = ~m | NP'(1 << p);
          @(negedge clk);
          cmd_valid = 1'b0;
          rem--;
          if (rem > 0) begin
            chk({tg, " R7 no early done"}, done, 0);
            chk({tg, " no early release"}, pe_out_valid, 0);
          end
          if (rem == 0) break;
        end
      end
    end else begin
      pe_valid = '1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    pe_valid = '0;

    n = 0;
    while (!done && n < 12) begin
      @(negedge clk);
      n++;
    end
    chk("R7 latency", n, (op == 3) ? 0 : LOG2);
    if (op == 3) begin
      chk("R8 release mask", pe_out_valid, m);
      chk("R8 result", result, 0);
    end else begin
      chk({tg, " R6 result"}, result, acc);
      if (op == 2) begin
        chk("R5 valid", pe_out_valid, m);
        for (int i = 0; i < NP; i++)
          if (m[i]) chk("R5 prefix", pe_out_data[i*W +: W], pre[i]);
      end else begin
        chk("R2 reduce no port valid", pe_out_valid, 0);
      end
    end
    @(negedge clk);
    chk("R9 stray cmd ignored / pulse", {done, pe_out_valid}, 0);
    chk("R9 idle after done", busy, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset", {busy, done, pe_out_valid, result}, 0);

    for (int m = 0; m < (1 << NP); m++)
      run_bcast(NP'(m), W'(8'h11 * (m + 1)));

    for (int op = 1; op <= 2; op++)
      for (int fn = 0; fn < 4; fn++)
        for (int m = 0; m < (1 << NP); m++)
          for (int pat = 0; pat < 2; pat++)
            run_op(op, fn, NP'(m), pat, bit'(pat ^ m), bit'(m >> 1));

    for (int m = 0; m < (1 << NP); m++)
      for (int s = 0; s < 2; s++)
        run_op(3, 0, NP'(m), 0, bit'(s), bit'(s ^ m));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule